// File: doc/BRIEF.md
# Event Timer with Source Select and Power-of-Two Prescaler

This block is an 8-bit up-counter that measures time or counts events. Each clock cycle it picks one count source. The first source is an instruction-cycle enable pulse from the surrounding core. The second is an edge on an external input pin. For the pin, the user chooses whether rising or falling edges count. The pin is resynchronised inside the block before its edges are detected.

An optional prescaler sits between the chosen source and the counter. It divides the event stream by a power of two from 2 to 256. When it is disabled, every event advances the counter. Software or a neighbouring block can load the counter with any value. It then expires after (256 − loaded value) × ratio source events. The expiry is marked by a sticky overflow flag that stays set until a clear strobe removes it.

The asynchronous active-low reset is released to the logic through a two-flop synchroniser. The block starts working two clock edges after `rst_n` rises.

Top module: `evt_timer8`

## Requirements
- R1: After reset, `count_o` is 0x00 and `ovf_o` is 0.
- R2: With `src_sel`=0 and `pre_en`=0, each cycle in which `cyc_tick` is 1 increments `count_o` by one at that clock edge. A cycle with `cyc_tick`=0 leaves the count unchanged. `ext_pin` has no effect on the count.
- R3: With `src_sel`=1, qualifying edges on `ext_pin` are counted. An edge is counted on the third rising clock edge after the pin changes. `cyc_tick` has no effect.
- R4: `fall_sel`=0 counts 0→1 transitions of `ext_pin` and `fall_sel`=1 counts 1→0 transitions. Each transition counts exactly once.
- R5: With `pre_en`=1, the counter advances once per 2^(`pre_code`+1) source events. Code 0 gives 1:2 and code 7 gives 1:256.
- R6: `load_en`=1 writes `load_val` into the counter at that edge and clears the prescaler phase. A load wins over an increment in the same cycle.
- R7: A change of `src_sel` or `pre_code` from its value in the previous cycle clears the prescaler phase. A source event in that same cycle is discarded.
- R8: An increment from 0xFF to 0x00 sets `ovf_o`. The flag stays set until a cycle with `ovf_clr`=1. If a set and a clear fall in the same cycle, the set wins. A load never sets the flag, and a load that beats an increment at 0xFF raises no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Instruction-cycle event pulse (internal source) |
| ext_pin | input | 1 | Asynchronous external count pin |
| src_sel | input | 1 | 0 = count `cyc_tick`, 1 = count pin edges |
| fall_sel | input | 1 | 0 = rising pin edges, 1 = falling pin edges |
| pre_en | input | 1 | 1 = prescaler in use, 0 = 1:1 |
| pre_code | input | 3 | Prescale ratio 2^(code+1) |
| load_en | input | 1 | Counter write strobe |
| load_val | input | 8 | Value written on `load_en` |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| count_o | output | 8 | Current counter value |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Loads, flag clears and increments from `cyc_tick` become visible one clock edge after the cycle that carries them. A pin transition shows on the count three edges later: two synchroniser stages, then the edge register. The bench drives inputs on the falling clock edge and models the same timing from the requirements. Each cycle's prediction is queued with the cycle number at which it is due. The monitor compares at the falling edge of exactly that cycle and flags any prediction that was left unchecked.

// File: rtl/evt_timer8_pkg.sv
package evt_timer8_pkg;

  localparam int unsigned DEF_CNT_W  = 8;
  localparam int unsigned DEF_CODE_W = 3;
  localparam int unsigned DEF_SYNC_N = 2;

  typedef enum logic {
    SRC_CYCLE = 1'b0,
    SRC_PIN   = 1'b1
  } src_e;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  import evt_timer8_pkg::*;

  logic [SYNC_N-1:0] sync_q;
  logic [SYNC_N-1:0] sync_d;
  logic              last_q;
  logic              last_d;
  logic              cur;

  assign cur = sync_q[SYNC_N-1];

  always_comb begin
    sync_d = {sync_q[SYNC_N-2:0], pin_i};
    last_d = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    if (edge_e'(fall_sel_i) == EDGE_FALL) begin
      edge_o = last_q & ~cur;
    end else begin
      edge_o = ~last_q & cur;
    end
  end

  // R4: one transition yields a single-cycle pulse while the polarity holds
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (!edge_o || (fall_sel_i != $past(fall_sel_i))));

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              clr_i,
  input  logic              evt_i,
  output logic              tick_o
);

  localparam int unsigned PRE_W = 1 << CODE_W;

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] pcnt_d;
  logic [PRE_W:0]   span;
  logic [PRE_W:0]   span_m1;
  logic             at_end;

  always_comb begin
    span    = (PRE_W+1)'(2) << code_i;
    span_m1 = span - (PRE_W+1)'(1);
    at_end  = (pcnt_q == span_m1[PRE_W-1:0]);
  end

  always_comb begin
    pcnt_d = pcnt_q;
    tick_o = 1'b0;
    if (!en_i) begin
      pcnt_d = '0;
      tick_o = evt_i;
    end else if (clr_i) begin
      pcnt_d = '0;
    end else if (evt_i) begin
      if (at_end) begin
        pcnt_d = '0;
        tick_o = 1'b1;
      end else begin
        pcnt_d = pcnt_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
    end
  end

  // R6 / R7: a clear request leaves the phase at zero
  assert_phase_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i || !en_i) |=> (pcnt_q == '0));

  // R5: a non-terminal event advances the phase by one
  assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && evt_i && !tick_o) |=> (pcnt_q == $past(pcnt_q) + PRE_W'(1)));

  // R5: no output tick without a source event
  assert_tick_needs_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> evt_i);

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             ovf_q;
  logic             ovf_d;
  logic             wrap;

  always_comb begin
    wrap  = inc_i & ~ld_i & (cnt_q == {CNT_W{1'b1}});
    cnt_d = cnt_q;
    if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (inc_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    ovf_d = ovf_q;
    if (wrap) begin
      ovf_d = 1'b1;
    end else if (ovf_clr_i) begin
      ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R6: load wins over increment
  assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (cnt_o == $past(ld_val_i)));

  // R2: an increment advances by exactly one
  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i) |=> (cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1))));

  // R2: no event, no load, no change
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !ld_i) |=> $stable(cnt_o));

  // R8: the flag stays up until a clear strobe
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  // R8: a roll-over always leaves the flag set, even against a clear
  assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && (cnt_o == {CNT_W{1'b1}})) |=> (ovf_o && (cnt_o == '0)));

endmodule

// File: rtl/evt_timer8.sv
module evt_timer8 #(
  parameter int unsigned CNT_W  = evt_timer8_pkg::DEF_CNT_W,
  parameter int unsigned CODE_W = evt_timer8_pkg::DEF_CODE_W,
  parameter int unsigned SYNC_N = evt_timer8_pkg::DEF_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_tick,
  input  logic              ext_pin,
  input  logic              src_sel,
  input  logic              fall_sel,
  input  logic              pre_en,
  input  logic [CODE_W-1:0] pre_code,
  input  logic              load_en,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              ovf_clr,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o
);
  import evt_timer8_pkg::*;

  localparam int unsigned CFG_W = CODE_W + 1;

  logic             srst_n;
  logic             pin_edge;
  logic             src_evt;
  logic             inc;
  logic             pre_clr;
  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;

  tmr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  tmr_pin_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk        (clk),
    .rst_n      (srst_n),
    .pin_i      (ext_pin),
    .fall_sel_i (fall_sel),
    .edge_o     (pin_edge)
  );

  always_comb begin
    cfg_now = {src_sel, pre_code};
    cfg_d   = cfg_now;
    pre_clr = load_en | (cfg_now != cfg_q);
    if (src_e'(src_sel) == SRC_PIN) begin
      src_evt = pin_edge;
    end else begin
      src_evt = cyc_tick;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  tmr_prescale #(.CODE_W(CODE_W)) u_pre (
    .clk    (clk),
    .rst_n  (srst_n),
    .en_i   (pre_en),
    .code_i (pre_code),
    .clr_i  (pre_clr),
    .evt_i  (src_evt),
    .tick_o (inc)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (srst_n),
    .inc_i     (inc),
    .ld_i      (load_en),
    .ld_val_i  (load_val),
    .ovf_clr_i (ovf_clr),
    .cnt_o     (count_o),
    .ovf_o     (ovf_o)
  );

  // R3: the tick input never drives the counter while the pin is selected
  assert_pin_source_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (src_sel && !pin_edge && !pre_en && !load_en) |=> $stable(count_o));

  // R1: state released from reset is cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(srst_n) |-> (count_o == '0 && !ovf_o));

endmodule

// File: tb/sim_evt_timer8.sv
module sim_evt_timer8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_tick, ext_pin, src_sel, fall_sel, pre_en;
  logic [2:0] pre_code;
  logic       load_en;
  logic [7:0] load_val;
  logic       ovf_clr;
  logic [7:0] count_o;
  logic       ovf_o;

  always #10 clk = ~clk;

  evt_timer8 u0 (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
    .src_sel(src_sel), .fall_sel(fall_sel), .pre_en(pre_en), .pre_code(pre_code),
    .load_en(load_en), .load_val(load_val), .ovf_clr(ovf_clr),
    .count_o(count_o), .ovf_o(ovf_o)
  );

  typedef struct {
    int         due;
    logic [7:0] cnt;
    logic       ovf;
    string      req;
  } exp_t;

  exp_t       sb[$];
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;
  logic [7:0] m_cnt;
  logic       m_ovf;
  int         m_pre;
  logic [3:0] hist;
  logic [3:0] cfg_prev;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops predictions when their cycle comes due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.due != cyc) begin
        errors++;
        $display("FAIL %s: prediction for cycle %0d missed, now %0d", e.req, e.due, cyc);
      end else if (count_o !== e.cnt || ovf_o !== e.ovf) begin
        errors++;
        $display("FAIL %s: count=%02h ovf=%b expected count=%02h ovf=%b",
                 e.req, count_o, ovf_o, e.cnt, e.ovf);
      end
    end
  end

  // driver: one clock cycle of stimulus plus its predicted result
  task automatic run(input logic t, input logic p, input logic ld,
                     input logic [7:0] lv, input logic cl, input string req);
    logic ext_ev, ev, chg, inc, wrap;
    int   term;
    exp_t e;
    cyc_tick = t; ext_pin = p; load_en = ld; load_val = lv; ovf_clr = cl;
    hist   = {hist[2:0], p};
    ext_ev = fall_sel ? (!hist[2] && hist[3]) : (hist[2] && !hist[3]);
    ev     = src_sel ? ext_ev : t;
    chg    = ({src_sel, pre_code} != cfg_prev);
    cfg_prev = {src_sel, pre_code};
    term   = 2 << pre_code;
    inc    = 1'b0;
    if (!pre_en) begin
      inc = ev; m_pre = 0;
    end else if (ld || chg) begin
      m_pre = 0;
    end else if (ev) begin
      if (m_pre == term - 1) begin inc = 1'b1; m_pre = 0; end
      else m_pre++;
    end
    wrap = inc && !ld && (m_cnt == 8'hFF);
    if (ld) m_cnt = lv;
    else if (inc) m_cnt = m_cnt + 8'd1;
    if (wrap) m_ovf = 1'b1;
    else if (cl) m_ovf = 1'b0;
    e.due = cyc + 1; e.cnt = m_cnt; e.ovf = m_ovf; e.req = req;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) run(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, req);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] pat;
    rst_n = 1'b0; cyc_tick = 0; ext_pin = 0; src_sel = 0; fall_sel = 0;
    pre_en = 0; pre_code = 3'd0; load_en = 0; load_val = 8'h00; ovf_clr = 0;
    m_cnt = 8'h00; m_ovf = 1'b0; m_pre = 0; hist = 4'h0; cfg_prev = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    run(0, 0, 0, 8'h00, 0, "R1");
    run(0, 0, 0, 8'h00, 0, "R1");

    // R2: internal source, 1:1, pin toggling is ignored
    for (int i = 0; i < 10; i++) run(logic'(i % 3 != 1), logic'(i % 2), 0, 8'h00, 0, "R2");

    // R3: pin source, rising edges, tick held high and ignored
    pat = 16'b0110_0011_1001_1100;
    src_sel = 1'b1;
    for (int i = 0; i < 16; i++) run(1, pat[i], 0, 8'h00, 0, "R3");
    for (int i = 0; i < 4; i++) run(1, pat[15], 0, 8'h00, 0, "R3");

    // R4: falling edges
    fall_sel = 1'b1;
    for (int i = 0; i < 16; i++) run(0, pat[i], 0, 8'h00, 0, "R4");
    for (int i = 0; i < 4; i++) run(0, pat[15], 0, 8'h00, 0, "R4");
    fall_sel = 1'b0;
    for (int i = 0; i < 8; i++) run(0, logic'(i % 2), 0, 8'h00, 0, "R4");
    for (int i = 0; i < 4; i++) run(0, 1'b1, 0, 8'h00, 0, "R4");
    src_sel = 1'b0;

    // R5: prescaler ratios 1:2, 1:8, 1:256
    pre_en = 1'b1; pre_code = 3'd0;
    ticks(9, "R5");
    pre_code = 3'd2;
    ticks(20, "R5");
    pre_code = 3'd7;
    ticks(520, "R5");

    // R6: load clears phase and beats increment
    pre_code = 3'd1;
    ticks(3, "R6");
    run(1, 0, 1, 8'h40, 0, "R6");
    ticks(6, "R6");
    pre_en = 1'b0;
    run(1, 0, 1, 8'h20, 0, "R6");
    ticks(2, "R6");

    // R7: config change clears phase
    pre_en = 1'b1; pre_code = 3'd2;
    ticks(5, "R7");
    pre_code = 3'd1;
    ticks(6, "R7");
    ticks(3, "R7");
    src_sel = 1'b1;
    run(1, 0, 0, 8'h00, 0, "R7");
    src_sel = 1'b0;
    ticks(5, "R7");

    // R8: overflow sticky, clear, set-wins, load never sets
    pre_en = 1'b0;
    run(0, 0, 1, 8'hFE, 0, "R8");
    ticks(2, "R8");
    for (int i = 0; i < 3; i++) run(0, 0, 0, 8'h00, 0, "R8");
    run(0, 0, 0, 8'h00, 1, "R8");
    run(0, 0, 1, 8'hFF, 0, "R8");
    run(1, 0, 0, 8'h00, 1, "R8");
    run(0, 0, 0, 8'h00, 1, "R8");
    run(0, 0, 1, 8'hFF, 0, "R8");
    run(1, 0, 1, 8'h05, 0, "R8");
    run(0, 0, 1, 8'hFF, 0, "R8");
    run(0, 0, 0, 8'h00, 0, "R8");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d predictions left, expected 0", sb.size());
    end
    finish_run();
  end

endmodule